// File: doc/BRIEF.md
# Two-Way Set-Associative Host Cache Controller

This block places a small write-back cache between a host processor and a slower external word memory. The cache has two ways. Each line holds eight 16-bit words. The host can write the high byte, the low byte or the whole word of any cached word. A read miss refills the whole line, and the word the host asked for is fetched first. That word is handed to the host as soon as it arrives, and the rest of the line then fills in wrapping order. Other hits are still served while the refill runs. Only a request for a word that has not yet arrived is held back.

A two-bit mode register, written by the host, sets how the next host request is read. In normal mode the request is a cached access. In flush mode, dirty data in one line is pushed out to memory from the given word through the end of the line. In invalidate mode, one line is dropped. In direct tag mode, software reads or writes a line's tag and control bits so it can initialise the cache. In flush and invalidate modes the way is picked by the lowest host address bit. External memory is reached through a word request/acknowledge port that carries one word per acknowledge.

Top module: `hcache_ctrl`

## Requirements
- R1: After reset `host_ack` and `mem_req` are low and every line of both ways reads back as invalid and clean with a zero LRU bit in direct tag mode.
- R2: On a normal-mode read miss the first memory read is the missed word. The host's acknowledge for that read arrives while the refill is still requesting memory.
- R3: A refill reads the rest of the line in wrapping order: missed word plus one, up to word 7, then from word 0. Every memory burst steps the word offset by one per acknowledge and keeps the upper address bits.
- R4: A host access to a word of the line being filled waits until that word has arrived. Hits to other lines are served during the refill.
- R5: `host_be[1]` selects the high byte and `host_be[0]` selects the low byte. A write hit changes only the selected lanes. A read returns zero in unselected lanes.
- R6: Write hits mark the line dirty and do not reach memory until the line is evicted or flushed.
- R7: A miss replaces an invalid way first, preferring way 0. Otherwise it replaces the way named by the set's LRU bit, which points away from the most recently used way. A dirty victim is written back as words 0 to 7 before the refill starts.
- R8: Mode encodings: 0 normal, 1 flush, 2 invalidate, 3 direct tag. A write on the mode port takes effect for the following requests.
- R9: Flush takes the set from the index field and the way from `host_addr[0]`. If the line is valid, it writes words from the address offset through word 7 to memory and then clears the dirty bit. Words below the offset are not written.
- R10: Invalidate takes the way from `host_addr[0]` and clears the line's valid and dirty bits. Dirty data is dropped, and the next access refetches from memory.
- R11: Direct tag mode uses the index field for the set and `host_addr[0]` for the way. A read returns valid in bit 15, dirty in bit 14, the set's LRU bit in bit 13, zeros below that, and the tag in the low bits. A write loads valid, dirty and tag from the same bit positions.
- R12: Each host request is answered by exactly one `host_ack` pulse of one cycle. `host_ack` only follows a cycle in which `host_req` was high.
- R13: While `mem_req` is high without `mem_ack`, the memory address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load the mode register |
| mode_wdata | input | 2 | New mode value |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | Host write (1) or read (0) |
| host_be | input | 2 | Byte lanes: bit 1 high byte, bit 0 low byte |
| host_addr | input | AW | Host word address: tag, set index, word offset |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with `host_ack` |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory has completed the current word |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |

## Verification
A refill word written into the data array and a host write hit served from the same array can land on the same clock edge. The same holds for a refill word arriving and a waiting host request being released. To provoke this, the bench starts a read miss and then issues a write and a read to an already filled line, followed by a read of the last word to arrive. The outcome is judged in two ways. First, `mem_req` must still be high when the hits are acknowledged, and low when the stalled read is acknowledged. Second, every value read back must match a byte-lane-aware shadow of the host's view of memory.

// File: rtl/hcache_ctrl.sv
module hcache_ctrl #(
  parameter int AW   = 16,
  parameter int IDXW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_be,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic          host_ack,
  output logic [15:0]   host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata
);
  localparam int OFFW = 3;
  localparam int WPL  = 1 << OFFW;
  localparam int SETS = 1 << IDXW;
  localparam int TAGW = AW - OFFW - IDXW;
  localparam int PADW = 13 - TAGW;
  localparam logic [1:0] M_NORM = 2'd0, M_FLUSH = 2'd1, M_INV = 2'd2, M_TAGD = 2'd3;

  typedef enum logic [1:0] {H_IDLE, H_WB, H_DONE} hst_t;

  hst_t hst;
  logic [1:0] mode;

  logic [TAGW-1:0]       tg  [2][SETS];
  logic [15:0]           dat [2][SETS][WPL];
  logic [1:0][SETS-1:0]  vld, dty;
  logic [SETS-1:0]       lru;

  logic            fill_act, fill_way;
  logic [IDXW-1:0] fill_set;
  logic [TAGW-1:0] fill_tag;
  logic [OFFW-1:0] fill_off, fill_cnt, fill_word;
  logic [WPL-1:0]  fmask;

  logic            wb_way, wb_ret;
  logic [IDXW-1:0] wb_set;
  logic [OFFW-1:0] wb_ptr;

  logic [OFFW-1:0] h_off;
  logic [IDXW-1:0] h_set;
  logic [TAGW-1:0] h_tag;
  logic            h_way;
  assign h_off = host_addr[OFFW-1:0];
  assign h_set = host_addr[OFFW+IDXW-1:OFFW];
  assign h_tag = host_addr[AW-1:OFFW+IDXW];
  assign h_way = host_addr[0];

  logic hit0, hit1, hit, hway, pending, vway, need_wb;
  assign hit0    = vld[0][h_set] && (tg[0][h_set] == h_tag);
  assign hit1    = vld[1][h_set] && (tg[1][h_set] == h_tag);
  assign hit     = hit0 | hit1;
  assign hway    = !hit0;
  assign pending = fill_act && (h_set == fill_set) && (hway == fill_way) && !fmask[h_off];
  assign vway    = !vld[0][h_set] ? 1'b0 : (!vld[1][h_set] ? 1'b1 : lru[h_set]);
  assign need_wb = vld[vway][h_set] && dty[vway][h_set];

  logic go, do_serve, do_miss, do_evict, do_cmd, do_tdw, fill_wr;
  assign go       = (hst == H_IDLE) && host_req;
  assign do_serve = go && (mode == M_NORM) && hit && !pending;
  assign do_miss  = go && (mode == M_NORM) && !hit && !fill_act && !need_wb;
  assign do_evict = go && (mode == M_NORM) && !hit && !fill_act && need_wb;
  assign do_cmd   = go && (mode != M_NORM) && !fill_act;
  assign do_tdw   = do_cmd && (mode == M_TAGD) && host_we;
  assign fill_wr  = fill_act && mem_ack;

  logic [15:0] cur, lanes, wmerge, tdr;
  assign cur    = dat[hway][h_set][h_off];
  assign lanes  = {{8{host_be[1]}}, {8{host_be[0]}}};
  assign wmerge = (cur & ~lanes) | (host_wdata & lanes);
  assign tdr    = {vld[h_way][h_set], dty[h_way][h_set], lru[h_set], {PADW{1'b0}}, tg[h_way][h_set]};

  assign fill_word = fill_off + fill_cnt;
  assign mem_req   = fill_act | (hst == H_WB);
  assign mem_we    = (hst == H_WB);
  assign mem_addr  = mem_we ? {tg[wb_way][wb_set], wb_set, wb_ptr} : {fill_tag, fill_set, fill_word};
  assign mem_wdata = dat[wb_way][wb_set][wb_ptr];
  assign host_ack  = (hst == H_DONE);

  always_ff @(posedge clk) begin
    if (fill_wr) dat[fill_way][fill_set][fill_word] <= mem_rdata;
    if (do_serve && host_we) dat[hway][h_set][h_off] <= wmerge;
    if (do_miss) tg[vway][h_set] <= h_tag;
    if (do_tdw) tg[h_way][h_set] <= host_wdata[TAGW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_NORM;
      hst        <= H_IDLE;
      vld        <= '0;
      dty        <= '0;
      lru        <= '0;
      fill_act   <= 1'b0;
      fill_way   <= 1'b0;
      fill_set   <= '0;
      fill_tag   <= '0;
      fill_off   <= '0;
      fill_cnt   <= '0;
      fmask      <= '0;
      wb_way     <= 1'b0;
      wb_ret     <= 1'b0;
      wb_set     <= '0;
      wb_ptr     <= '0;
      host_rdata <= '0;
    end else begin
      if (mode_we) mode <= mode_wdata;
      if (fill_wr) begin
        fmask[fill_word] <= 1'b1;
        fill_cnt <= fill_cnt + 3'd1;
        if (fill_cnt == 3'd7) fill_act <= 1'b0;
      end
      case (hst)
        H_IDLE: begin
          if (do_serve) begin
            hst <= H_DONE;
            lru[h_set] <= ~hway;
            host_rdata <= host_we ? 16'h0 : (cur & lanes);
            if (host_we) dty[hway][h_set] <= 1'b1;
          end else if (do_miss) begin
            vld[vway][h_set] <= 1'b1;
            dty[vway][h_set] <= 1'b0;
            lru[h_set] <= ~vway;
            fill_act <= 1'b1;
            fill_way <= vway;
            fill_set <= h_set;
            fill_tag <= h_tag;
            fill_off <= h_off;
            fill_cnt <= '0;
            fmask    <= '0;
          end else if (do_evict) begin
            hst    <= H_WB;
            wb_way <= vway;
            wb_set <= h_set;
            wb_ptr <= '0;
            wb_ret <= 1'b0;
          end else if (do_cmd) begin
            hst <= H_DONE;
            host_rdata <= '0;
            case (mode)
              M_FLUSH: if (vld[h_way][h_set]) begin
                hst    <= H_WB;
                wb_way <= h_way;
                wb_set <= h_set;
                wb_ptr <= h_off;
                wb_ret <= 1'b1;
              end
              M_INV: begin
                vld[h_way][h_set] <= 1'b0;
                dty[h_way][h_set] <= 1'b0;
              end
              M_TAGD: if (host_we) begin
                vld[h_way][h_set] <= host_wdata[15];
                dty[h_way][h_set] <= host_wdata[14];
              end else begin
                host_rdata <= tdr;
              end
              default: ;
            endcase
          end
        end
        H_WB: if (mem_ack) begin
          wb_ptr <= wb_ptr + 3'd1;
          if (wb_ptr == 3'd7) begin
            dty[wb_way][wb_set] <= 1'b0;
            hst <= wb_ret ? H_DONE : H_IDLE;
          end
        end
        default: hst <= H_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcache_ctrl_chk.sv
module hcache_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr
);
  AST_ACK_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack); // R12
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(host_req)); // R12
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req ||
      ((mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1) && (mem_addr[AW-1:3] == $past(mem_addr[AW-1:3]))))); // R3
endmodule

bind hcache_ctrl hcache_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/hcache_ctrl_test.sv
module hcache_ctrl_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_we = 1'b0;
  logic [1:0] m_wd = 2'd0;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [1:0] h_be = 2'b11;
  logic [15:0] h_addr = '0, h_wd = '0;
  logic host_ack, mem_req, mem_we;
  logic [15:0] host_rdata, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int total = 0, bad = 0;
  logic [15:0] bmem [int unsigned];
  logic [15:0] hv   [int unsigned];
  logic [15:0] exp_q [$];
  bit          chk_q [$];
  string       rq_q  [$];

  always #(CLK_NS/2) clk = ~clk;

  hcache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_we(m_we), .mode_wdata(m_wd),
    .host_req(h_req), .host_we(h_we), .host_be(h_be), .host_addr(h_addr), .host_wdata(h_wd),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [15:0] init(int unsigned a);
    return 16'(a * 3) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] memget(int unsigned a);
    return bmem.exists(a) ? bmem[a] : init(a);
  endfunction
  function automatic logic [15:0] hvget(int unsigned a);
    return hv.exists(a) ? hv[a] : init(a);
  endfunction
  function automatic logic [15:0] lanes(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction
  function automatic logic [15:0] mk(int t, int s, int o);
    return 16'((t << 7) | (s << 3) | o);
  endfunction

  task automatic check(string rq, logic [15:0] act, logic [15:0] ex);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, ex);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) bmem[mem_addr] = mem_wdata;
      else mem_rdata <= memget(mem_addr);
    end else begin
      mem_ack <= 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && host_ack) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected ack", 16'h1, 16'h0);
      end else begin
        logic [15:0] ex;
        bit want;
        string rq;
        ex = exp_q.pop_front();
        want = chk_q.pop_front();
        rq = rq_q.pop_front();
        if (want) check(rq, host_rdata, ex);
      end
    end
  end

  task automatic host_op(bit we, logic [1:0] be, logic [15:0] a, logic [15:0] wd,
                         bit want, logic [15:0] ex, string rq);
    exp_q.push_back(ex);
    chk_q.push_back(want);
    rq_q.push_back(rq);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_be = be; h_addr = a; h_wd = wd;
    do @(negedge clk); while (!host_ack);
    h_req = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [1:0] be, string rq);
    host_op(1'b0, be, a, 16'h0, 1'b1, hvget(a) & lanes(be), rq);
  endtask

  task automatic wr(logic [15:0] a, logic [1:0] be, logic [15:0] d, string rq);
    hv[a] = (hvget(a) & ~lanes(be)) | (d & lanes(be));
    host_op(1'b1, be, a, d, 1'b0, 16'h0, rq);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    m_we = 1'b1; m_wd = m;
    @(negedge clk);
    m_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack after reset", {15'h0, host_ack}, 16'h0);
    check("R1 mem_req after reset", {15'h0, mem_req}, 16'h0);
    rst_n = 1'b1;

    set_mode(2'd3);
    host_op(1'b0, 2'b11, mk(0, 3, 1), 16'h0, 1'b1, 16'h0000, "R1 R11 tag read after reset");
    set_mode(2'd0);

    rd(mk(1, 1, 5), 2'b11, "R2 critical word");
    check("R2 refill still running at ack", {15'h0, mem_req}, 16'h1);
    rd(mk(1, 1, 4), 2'b11, "R3 R4 last wrapped word");
    check("R3 R4 stalled read acked after refill", {15'h0, mem_req}, 16'h0);

    rd(mk(2, 2, 0), 2'b11, "R2 second miss");
    wr(mk(1, 1, 3), 2'b10, 16'hBE00, "R4 write hit during refill");
    check("R4 write hit served during refill", {15'h0, mem_req}, 16'h1);
    rd(mk(1, 1, 3), 2'b11, "R4 R5 readback during refill");
    check("R4 read hit served during refill", {15'h0, mem_req}, 16'h1);
    rd(mk(2, 2, 7), 2'b11, "R3 end of refilled line");

    wr(mk(1, 1, 6), 2'b01, 16'h12AB, "R5 low byte write");
    rd(mk(1, 1, 6), 2'b10, "R5 high lane read");
    rd(mk(1, 1, 6), 2'b01, "R5 low lane read");

    wr(mk(2, 2, 1), 2'b11, 16'hC0DE, "R6 dirty write");
    check("R6 memory stale after write hit", memget(mk(2, 2, 1)), init(mk(2, 2, 1)));
    rd(mk(3, 2, 0), 2'b11, "R7 fill invalid way");
    rd(mk(4, 2, 0), 2'b11, "R7 evict dirty victim");
    check("R7 victim written back", memget(mk(2, 2, 1)), 16'hC0DE);
    rd(mk(2, 2, 1), 2'b11, "R7 refetch evicted line");

    set_mode(2'd3);
    host_op(1'b0, 2'b11, mk(0, 2, 1), 16'h0, 1'b1, 16'h8002, "R7 R11 way1 tag after replacement");
    host_op(1'b0, 2'b11, mk(0, 2, 0), 16'h0, 1'b1, 16'h8004, "R7 R11 way0 tag after replacement");
    set_mode(2'd0);

    rd(mk(7, 5, 0), 2'b11, "R9 setup fill");
    wr(mk(7, 5, 0), 2'b11, 16'h1111, "R9 setup write low word");
    wr(mk(7, 5, 4), 2'b11, 16'h4444, "R9 setup write word 4");
    set_mode(2'd1);
    host_op(1'b0, 2'b11, mk(7, 5, 2), 16'h0, 1'b0, 16'h0, "R8 R9 flush");
    check("R9 word 4 flushed", memget(mk(7, 5, 4)), 16'h4444);
    check("R9 word 7 flushed", memget(mk(7, 5, 7)), hvget(mk(7, 5, 7)));
    check("R9 word 0 below offset untouched", memget(mk(7, 5, 0)), init(mk(7, 5, 0)));
    set_mode(2'd3);
    host_op(1'b0, 2'b11, mk(0, 5, 0), 16'h0, 1'b1, 16'hA007, "R9 R11 dirty cleared by flush");

    set_mode(2'd0);
    rd(mk(8, 6, 3), 2'b11, "R10 setup fill");
    wr(mk(8, 6, 3), 2'b11, 16'hDEAD, "R10 setup dirty write");
    set_mode(2'd2);
    host_op(1'b0, 2'b11, mk(8, 6, 2), 16'h0, 1'b0, 16'h0, "R8 R10 invalidate even");
    for (int k = 0; k < 8; k++) hv[mk(8, 6, k)] = memget(mk(8, 6, k));
    set_mode(2'd0);
    rd(mk(8, 6, 3), 2'b11, "R10 dirty data dropped, refetched");
    rd(mk(9, 6, 0), 2'b11, "R10 fill way1");
    set_mode(2'd2);
    host_op(1'b0, 2'b11, mk(9, 6, 1), 16'h0, 1'b0, 16'h0, "R10 invalidate odd");
    set_mode(2'd3);
    host_op(1'b0, 2'b11, mk(0, 6, 1), 16'h0, 1'b1, 16'h0009, "R10 R11 odd address cleared way1");
    host_op(1'b0, 2'b11, mk(0, 6, 0), 16'h0, 1'b1, 16'h8008, "R10 R11 way0 kept");

    host_op(1'b1, 2'b11, mk(0, 3, 1), 16'hC055, 1'b0, 16'h0, "R11 tag write");
    host_op(1'b0, 2'b11, mk(0, 3, 1), 16'h0, 1'b1, 16'hC055, "R11 tag readback");
    set_mode(2'd0);

    repeat (4) @(negedge clk);
    check("R12 every request acknowledged once", 16'(exp_q.size()), 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule